// File: doc/BRIEF.md
# Switching Regulator Fault Supervisor

This block is the digital fault supervisor of a synchronous buck regulator. It is clocked once per switching cycle and receives only comparator results: feedback too low, feedback too high, the two discharge hysteresis levels, switch node high, die hot, die cooled, and the two enable-pin levels. From these it decides when the converter must stop, requests the low-side switch to drain the output without driving it negative, and runs the restart sequence.

Each fault source is qualified in its own way. Feedback under-voltage must last a configurable run of consecutive cycles and is ignored during soft-start. Over-voltage needs a shorter run and is armed even during soft-start. A shorted high-side switch and die over-temperature trip on the first cycle they are seen. A two-bit provisioning input selects between staying off, latching off after a fault, and restarting on its own through an enable-pin discharge and recharge handshake.

Top module: `fault_supervisor`

## Requirements
- R1: A synchronous active-high reset leaves faultLatch 0, faultCause 0, dischargeReq 0, enSinkReq 0, powerGood 0, pwmDisable 1 and restartStatus 0 (off).
- R2: While running, uvFlag high for UV_CYCLES consecutive cycles sets the fault latch with faultCause 1; any cycle without it restarts the count from zero.
- R3: uvFlag does not advance the under-voltage count while softStart is high.
- R4: ovFlag high for OV_CYCLES consecutive cycles sets the latch with faultCause 2, also during soft-start; a shorter run does not.
- R5: swHigh together with lowSideOn sets the latch on that cycle with faultCause 3; swHigh alone does not.
- R6: overTemp sets the latch with faultCause 4; in auto-restart the enable sink is held until tempRecovered is high.
- R7: When the latch is set dischargeReq goes to 1; it drops when fbBelowLow is seen and returns only when fbAboveHigh is seen, and is 0 whenever the latch is clear.
- R8: modeSel 1 (latched off): after a fault restartStatus stays 4, the latch stays set and the enable flags have no effect.
- R9: modeSel 2 or 3 (auto restart): after a fault restartStatus is 2 with enSinkReq 1 until enBelowOff, then 3 with the sink released until enAboveOn, then 1 (running) with the latch clear and faultCause 0.
- R10: modeSel 0 (disabled) moves to restartStatus 0 on the next edge from any state, clears the latch and holds pwmDisable 1; enabling needs modeSel not 0 and enAboveOn.
- R11: powerGood is 1 only in cycles after an edge that leaves the block running with softStart 0 and pgWindowOk 1; it is never 1 while the latch is set.
- R12: faultCause records the first fault only; on a simultaneous trip the priority is short, then OV, then OTP, then UV, and the value is held until the latch clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One edge per switching cycle |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 2 | 0 disabled, 1 latched off, 2 auto restart (open), 3 auto restart (timed) |
| uvFlag | input | 1 | Feedback below under-voltage level |
| ovFlag | input | 1 | Feedback above over-voltage level |
| fbBelowLow | input | 1 | Feedback below the discharge stop level |
| fbAboveHigh | input | 1 | Feedback above the discharge resume level |
| swHigh | input | 1 | Switch node above the short detection level |
| lowSideOn | input | 1 | Low-side switch fully on |
| overTemp | input | 1 | Die above shutdown temperature |
| tempRecovered | input | 1 | Die below restart temperature |
| softStart | input | 1 | Soft-start ramp in progress |
| enBelowOff | input | 1 | Enable pin below its discharge level |
| enAboveOn | input | 1 | Enable pin above its start level |
| pgWindowOk | input | 1 | Output inside the regulation window |
| faultLatch | output | 1 | Sticky fault latch |
| dischargeReq | output | 1 | Request to turn the low-side switch on for discharge |
| pwmDisable | output | 1 | Switching stopped |
| enSinkReq | output | 1 | Enable-pin sink current on |
| powerGood | output | 1 | Output in regulation |
| restartStatus | output | 3 | 0 off, 1 running, 2 sinking enable, 3 waiting for enable, 4 latched off |
| faultCause | output | 3 | 0 none, 1 UV, 2 OV, 3 short, 4 over-temperature |

## Verification
The bench builds the block with UV_CYCLES set to 4 and OV_CYCLES left at 2, which makes every run length of each flag from one cycle to the trip point reachable in a short sweep, along with a broken run. With those lengths, the overlap of an under-voltage trip and an over-voltage run, every provisioning mode, and each step of the restart handshake take only a few cycles each.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RUN   = 3'd1,
    ST_SINK  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_LATCH = 3'd4
  } supState_t;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_UV    = 3'd1,
    CAUSE_OV    = 3'd2,
    CAUSE_SHORT = 3'd3,
    CAUSE_OTP   = 3'd4
  } cause_t;

  localparam logic [1:0] MODE_DISABLED = 2'd0;
  localparam logic [1:0] MODE_HOLD     = 2'd1;

  // control -> datapath
  typedef struct packed {
    logic arm;
    logic clear;
  } qualStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic shortTrip;
    logic ovTrip;
    logic otpTrip;
    logic uvTrip;
  } tripVec_t;
endpackage

// File: rtl/fsup_runcount.sv
module fsup_runcount #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic cond,
  output logic hit
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] runCnt;

  assign hit = cond && (runCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || !cond) runCnt <= '0;
    else if (runCnt != LAST)   runCnt <= runCnt + W'(1);
  end
endmodule

// File: rtl/fsup_qualify.sv
module fsup_qualify
  import fsup_pkg::*;
#(
  parameter int UV_CYCLES = 16,
  parameter int OV_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  qualStrobe_t strobe,
  input  logic        uvFlag,
  input  logic        ovFlag,
  input  logic        softStart,
  input  logic        swHigh,
  input  logic        lowSideOn,
  input  logic        overTemp,
  output tripVec_t    trips
);
  logic uvHit, ovHit;

  fsup_runcount #(.LEN(UV_CYCLES)) u_uvRun (
    .clk(clk), .rst(rst), .clear(strobe.clear),
    .cond(strobe.arm && uvFlag && !softStart), .hit(uvHit)
  );

  fsup_runcount #(.LEN(OV_CYCLES)) u_ovRun (
    .clk(clk), .rst(rst), .clear(strobe.clear),
    .cond(strobe.arm && ovFlag), .hit(ovHit)
  );

  always_comb begin
    trips.uvTrip    = uvHit;
    trips.ovTrip    = ovHit;
    trips.shortTrip = strobe.arm && swHigh && lowSideOn;
    trips.otpTrip   = strobe.arm && overTemp;
  end
endmodule

// File: rtl/fsup_control.sv
module fsup_control
  import fsup_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  input  tripVec_t    trips,
  input  logic        fbBelowLow,
  input  logic        fbAboveHigh,
  input  logic        tempRecovered,
  input  logic        softStart,
  input  logic        enBelowOff,
  input  logic        enAboveOn,
  input  logic        pgWindowOk,
  output qualStrobe_t strobe,
  output logic        faultLatch,
  output logic        dischargeReq,
  output logic        pwmDisable,
  output logic        enSinkReq,
  output logic        powerGood,
  output logic [2:0]  restartStatus,
  output logic [2:0]  faultCause
);
  supState_t state, stateNext;
  cause_t    cause, firstCause;
  logic      dischReg, pgReg, anyTrip;

  assign anyTrip = |trips;

  always_comb begin
    if (trips.shortTrip)    firstCause = CAUSE_SHORT;
    else if (trips.ovTrip)  firstCause = CAUSE_OV;
    else if (trips.otpTrip) firstCause = CAUSE_OTP;
    else if (trips.uvTrip)  firstCause = CAUSE_UV;
    else                    firstCause = CAUSE_NONE;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF:   if (enAboveOn) stateNext = ST_RUN;
      ST_RUN:   if (anyTrip) stateNext = (modeSel == MODE_HOLD) ? ST_LATCH : ST_SINK;
      ST_SINK:  if (enBelowOff && (cause != CAUSE_OTP || tempRecovered)) stateNext = ST_WAIT;
      ST_WAIT:  if (enAboveOn) stateNext = ST_RUN;
      ST_LATCH: stateNext = ST_LATCH;
      default:  stateNext = ST_OFF;
    endcase
    if (modeSel == MODE_DISABLED) stateNext = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      cause    <= CAUSE_NONE;
      dischReg <= 1'b0;
      pgReg    <= 1'b0;
    end else begin
      state <= stateNext;
      pgReg <= (stateNext == ST_RUN) && !softStart && pgWindowOk;
      if (stateNext == ST_RUN || stateNext == ST_OFF) begin
        cause    <= CAUSE_NONE;
        dischReg <= 1'b0;
      end else if (state == ST_RUN) begin
        cause    <= firstCause;
        dischReg <= 1'b1;
      end else begin
        dischReg <= dischReg ? !fbBelowLow : fbAboveHigh;
      end
    end
  end

  always_comb begin
    strobe.arm    = (state == ST_RUN);
    strobe.clear  = (state != ST_RUN);
    faultLatch    = (state == ST_SINK) || (state == ST_WAIT) || (state == ST_LATCH);
    dischargeReq  = dischReg;
    pwmDisable    = (state != ST_RUN);
    enSinkReq     = (state == ST_SINK);
    powerGood     = pgReg;
    restartStatus = state;
    faultCause    = cause;
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int UV_CYCLES = 16,
  parameter int OV_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       uvFlag,
  input  logic       ovFlag,
  input  logic       fbBelowLow,
  input  logic       fbAboveHigh,
  input  logic       swHigh,
  input  logic       lowSideOn,
  input  logic       overTemp,
  input  logic       tempRecovered,
  input  logic       softStart,
  input  logic       enBelowOff,
  input  logic       enAboveOn,
  input  logic       pgWindowOk,
  output logic       faultLatch,
  output logic       dischargeReq,
  output logic       pwmDisable,
  output logic       enSinkReq,
  output logic       powerGood,
  output logic [2:0] restartStatus,
  output logic [2:0] faultCause
);
  qualStrobe_t strobe;
  tripVec_t    trips;

  fsup_qualify #(.UV_CYCLES(UV_CYCLES), .OV_CYCLES(OV_CYCLES)) u_qualify (
    .clk(clk), .rst(rst), .strobe(strobe),
    .uvFlag(uvFlag), .ovFlag(ovFlag), .softStart(softStart),
    .swHigh(swHigh), .lowSideOn(lowSideOn), .overTemp(overTemp),
    .trips(trips)
  );

  fsup_control u_control (
    .clk(clk), .rst(rst), .modeSel(modeSel), .trips(trips),
    .fbBelowLow(fbBelowLow), .fbAboveHigh(fbAboveHigh),
    .tempRecovered(tempRecovered), .softStart(softStart),
    .enBelowOff(enBelowOff), .enAboveOn(enAboveOn), .pgWindowOk(pgWindowOk),
    .strobe(strobe), .faultLatch(faultLatch), .dischargeReq(dischargeReq),
    .pwmDisable(pwmDisable), .enSinkReq(enSinkReq), .powerGood(powerGood),
    .restartStatus(restartStatus), .faultCause(faultCause)
  );
endmodule

// File: rtl/fault_supervisor_checker.sv
module fault_supervisor_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] modeSel,
  input logic       swHigh,
  input logic       lowSideOn,
  input logic       enBelowOff,
  input logic       faultLatch,
  input logic       dischargeReq,
  input logic       pwmDisable,
  input logic       enSinkReq,
  input logic       powerGood,
  input logic [2:0] restartStatus,
  input logic [2:0] faultCause
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!faultLatch && !powerGood && !dischargeReq && restartStatus == 3'd0));

  a_r5_short_trips_now: assert property (@(posedge clk) disable iff (rst)
    (restartStatus == 3'd1 && swHigh && lowSideOn && modeSel != 2'd0) |=> faultLatch);

  a_r7_discharge_needs_latch: assert property (@(posedge clk) disable iff (rst)
    dischargeReq |-> faultLatch);

  a_r8_latched_holds: assert property (@(posedge clk) disable iff (rst)
    (restartStatus == 3'd4 && modeSel != 2'd0) |=> (restartStatus == 3'd4 && faultLatch));

  a_r9_sink_holds: assert property (@(posedge clk) disable iff (rst)
    (restartStatus == 3'd2 && !enBelowOff && modeSel != 2'd0) |=> (restartStatus == 3'd2 && enSinkReq));

  a_r10_disable_stops: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'd0) |=> (pwmDisable && !faultLatch));

  a_r11_pg_not_in_fault: assert property (@(posedge clk) disable iff (rst)
    powerGood |-> (!faultLatch && !pwmDisable));

  a_r12_cause_held: assert property (@(posedge clk) disable iff (rst)
    (faultLatch && modeSel != 2'd0) |=> (!faultLatch || $stable(faultCause)));

  a_r12_cause_set: assert property (@(posedge clk) disable iff (rst)
    faultLatch |-> (faultCause != 3'd0));
endmodule

bind fault_supervisor fault_supervisor_checker u_checker (
  .clk(clk), .rst(rst), .modeSel(modeSel), .swHigh(swHigh), .lowSideOn(lowSideOn),
  .enBelowOff(enBelowOff), .faultLatch(faultLatch), .dischargeReq(dischargeReq),
  .pwmDisable(pwmDisable), .enSinkReq(enSinkReq), .powerGood(powerGood),
  .restartStatus(restartStatus), .faultCause(faultCause)
);

// File: tb/fault_supervisor_tb.sv
`timescale 1ns/1ps
module fault_supervisor_tb;
  localparam int UVN = 4;
  localparam int OVN = 2;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] modeSel;
  logic uvFlag, ovFlag, fbBelowLow, fbAboveHigh, swHigh, lowSideOn;
  logic overTemp, tempRecovered, softStart, enBelowOff, enAboveOn, pgWindowOk;
  logic faultLatch, dischargeReq, pwmDisable, enSinkReq, powerGood;
  logic [2:0] restartStatus, faultCause;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.UV_CYCLES(UVN), .OV_CYCLES(OVN)) u_dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .uvFlag(uvFlag), .ovFlag(ovFlag),
    .fbBelowLow(fbBelowLow), .fbAboveHigh(fbAboveHigh), .swHigh(swHigh),
    .lowSideOn(lowSideOn), .overTemp(overTemp), .tempRecovered(tempRecovered),
    .softStart(softStart), .enBelowOff(enBelowOff), .enAboveOn(enAboveOn),
    .pgWindowOk(pgWindowOk), .faultLatch(faultLatch), .dischargeReq(dischargeReq),
    .pwmDisable(pwmDisable), .enSinkReq(enSinkReq), .powerGood(powerGood),
    .restartStatus(restartStatus), .faultCause(faultCause)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic clearFlags();
    uvFlag = 0; ovFlag = 0; fbBelowLow = 0; fbAboveHigh = 0; swHigh = 0;
    lowSideOn = 0; overTemp = 0; tempRecovered = 0; softStart = 0;
    enBelowOff = 0; pgWindowOk = 1;
  endtask

  // reset, then enter running with the given mode
  task automatic goRun(input logic [1:0] m);
    clearFlags();
    modeSel = m; enAboveOn = 1; rst = 1;
    tick();
    rst = 0;
    tick();
    check("R10 enters running", restartStatus, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearFlags();
    modeSel = 2; enAboveOn = 0; rst = 1;
    tick(2);
    // R1 reset state
    check("R1 latch", faultLatch, 0);
    check("R1 cause", faultCause, 0);
    check("R1 discharge", dischargeReq, 0);
    check("R1 sink", enSinkReq, 0);
    check("R1 pg", powerGood, 0);
    check("R1 pwm", pwmDisable, 1);
    check("R1 status", restartStatus, 0);

    // R10: disabled mode never starts
    rst = 0; modeSel = 0; enAboveOn = 1;
    tick(3);
    check("R10 stays off", restartStatus, 0);
    check("R10 pwm", pwmDisable, 1);

    // R2 sweep of under-voltage run lengths
    for (int k = 1; k <= UVN + 1; k++) begin
      goRun(2);
      uvFlag = 1;
      tick(k);
      uvFlag = 0;
      check("R2 uv run", faultLatch, (k >= UVN) ? 1 : 0);
      if (k >= UVN) check("R2 uv cause", faultCause, 1);
    end
    // R2 broken run never trips
    goRun(2);
    uvFlag = 1; tick(UVN - 1);
    uvFlag = 0; tick();
    uvFlag = 1; tick(UVN - 1);
    check("R2 broken run", faultLatch, 0);
    tick();
    check("R2 run after gap", faultLatch, 1);
    uvFlag = 0;

    // R3 soft-start masks UV, OV still armed
    goRun(2);
    softStart = 1; uvFlag = 1;
    tick(2 * UVN);
    check("R3 masked", faultLatch, 0);
    softStart = 0;
    tick(UVN - 1);
    check("R3 count from zero", faultLatch, 0);
    tick();
    check("R3 trips after ss", faultLatch, 1);
    uvFlag = 0;

    // R4 over-voltage sweep, during soft-start
    for (int k = 1; k <= OVN + 1; k++) begin
      goRun(3);
      softStart = 1; ovFlag = 1;
      tick(k);
      ovFlag = 0;
      check("R4 ov run", faultLatch, (k >= OVN) ? 1 : 0);
      if (k >= OVN) check("R4 ov cause", faultCause, 2);
    end

    // R5 short
    goRun(2);
    swHigh = 1; tick(3);
    check("R5 swHigh alone", faultLatch, 0);
    lowSideOn = 1; tick();
    check("R5 short trips", faultLatch, 1);
    check("R5 cause", faultCause, 3);
    swHigh = 0; lowSideOn = 0;

    // R12 priority on simultaneous trips
    goRun(2);
    ovFlag = 1; tick();
    swHigh = 1; lowSideOn = 1; tick();
    check("R12 short beats ov", faultCause, 3);
    goRun(2);
    uvFlag = 1; tick(UVN - 1);
    ovFlag = 1; tick();
    check("R12 first fault uv", faultCause, 1);
    tick(3);
    check("R12 cause held", faultCause, 1);
    uvFlag = 0; ovFlag = 0;

    // R7 discharge hysteresis and R9 restart handshake
    goRun(2);
    swHigh = 1; lowSideOn = 1; tick();
    swHigh = 0; lowSideOn = 0;
    check("R7 discharge on at fault", dischargeReq, 1);
    check("R9 sinking", restartStatus, 2);
    check("R9 sink on", enSinkReq, 1);
    fbBelowLow = 1; tick();
    check("R7 stops below low", dischargeReq, 0);
    fbBelowLow = 0; tick(2);
    check("R7 stays off in band", dischargeReq, 0);
    fbAboveHigh = 1; tick();
    check("R7 resumes above high", dischargeReq, 1);
    fbAboveHigh = 0; tick();
    check("R7 stays on in band", dischargeReq, 1);
    enAboveOn = 0; enBelowOff = 1; tick();
    check("R9 waiting", restartStatus, 3);
    check("R9 sink released", enSinkReq, 0);
    check("R9 latch held", faultLatch, 1);
    enBelowOff = 0; tick(2);
    check("R9 still waiting", restartStatus, 3);
    enAboveOn = 1; tick();
    check("R9 running", restartStatus, 1);
    check("R9 latch clear", faultLatch, 0);
    check("R9 cause clear", faultCause, 0);
    check("R7 off when clear", dischargeReq, 0);

    // R6 over-temperature gating
    goRun(2);
    overTemp = 1; tick();
    overTemp = 0;
    check("R6 otp cause", faultCause, 4);
    enAboveOn = 0; enBelowOff = 1; tick(2);
    check("R6 held hot", restartStatus, 2);
    tempRecovered = 1; tick();
    check("R6 released cool", restartStatus, 3);

    // R8 latched-off mode
    goRun(1);
    swHigh = 1; lowSideOn = 1; tick();
    swHigh = 0; lowSideOn = 0;
    check("R8 latched", restartStatus, 4);
    enAboveOn = 0; enBelowOff = 1; tick(2);
    enAboveOn = 1; enBelowOff = 0; tick(2);
    check("R8 still latched", restartStatus, 4);
    check("R8 latch", faultLatch, 1);
    check("R8 no sink", enSinkReq, 0);
    // R10 disable clears latch
    modeSel = 0; tick();
    check("R10 off", restartStatus, 0);
    check("R10 latch cleared", faultLatch, 0);
    check("R10 pwm disabled", pwmDisable, 1);

    // R11 power good
    clearFlags(); modeSel = 2; enAboveOn = 1; rst = 1; tick(); rst = 0;
    check("R11 low in off", powerGood, 0);
    tick();
    check("R11 high on entry", powerGood, 1);
    softStart = 1; tick();
    check("R11 low in soft-start", powerGood, 0);
    softStart = 0; pgWindowOk = 0; tick();
    check("R11 low out of window", powerGood, 0);
    pgWindowOk = 1; tick();
    check("R11 back high", powerGood, 1);
    overTemp = 1; tick();
    overTemp = 0;
    check("R11 low at fault", powerGood, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule